// File: doc/BRIEF.md
# Predicated Vector Floating-Point Comparator

This block compares two vector operands lane by lane as floating-point numbers and produces a predicate with one bit per byte of the vector. A two-part opcode field selects one of seven relations: ordered greater-or-equal and greater-than, quiet equal, not-equal and unordered, and greater-or-equal and greater-than on absolute values. A two-bit size code selects 16-bit, 32-bit or 64-bit lanes. A governing predicate, also one bit per byte, decides which lanes take part. Lanes that are off produce zero and raise no exception.

Each compare request is presented with `in_valid` for one cycle, and the registered result appears one cycle later. Alongside the predicate, the block keeps a sticky invalid-operation flag. Any lane that is on and meets its invalid condition sets the flag, and the flag stays set until `flag_clr` is pulsed. Flush-to-zero is controlled by two separate inputs: one for half precision and one for single and double precision.

Top module: `vfp_cmp_top`

## Requirements
- R1: The opcode `{op_field, op_bit}` selects the relation: 010/0 a>=b, 010/1 a>b, 011/0 a==b, 011/1 a!=b, 110/0 unordered, 110/1 |a|>=|b|, 111/1 |a|>|b|.
- R2: A size code of 00, or any other opcode pair, is an undefined encoding. The result has `undef_enc`=1 and an all-zero predicate, and the sticky flag does not change.
- R3: Size codes 01, 10 and 11 select 16-, 32- and 64-bit lanes. Lane k starts at byte k times the lane size. A lane's result goes in the predicate bit of its lowest byte, and every other bit of its span is 0.
- R4: A lane is on only when `gov_pred` is 1 at the lane's lowest byte. A lane that is off gives 0 and adds nothing to the invalid flag, whatever its other governing bits hold.
- R5: Greater-or-equal and greater-than give false if either operand is any NaN, and that lane raises invalid.
- R6: Equal, not-equal and unordered raise invalid only for a signalling NaN (exponent all ones, nonzero mantissa, mantissa MSB 0). When a NaN is present, not-equal and unordered give true and equal gives false.
- R7: The absolute forms ignore both sign bits and raise invalid on any NaN, as in R5.
- R8: +0 and -0 compare equal. Infinities order as the largest magnitudes of their sign.
- R9: When `ftz_half` is 1, a 16-bit denormal operand is treated as zero. When `ftz_wide` is 1, the same applies to 32-bit and 64-bit lanes. Each input has no effect on the other sizes.
- R10: `inv_sticky` is the running OR of the lane invalid conditions of accepted requests. If `flag_clr` is 1 at an edge, the old value is discarded first, and a request accepted at the same edge still contributes.
- R11: `res_valid`, `res_pred` and `undef_enc` are registered one cycle after `in_valid`. While `res_valid` is 0, `res_pred` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Compare request this cycle |
| op_field | input | 3 | Major opcode field |
| op_bit | input | 1 | Minor opcode bit |
| elem_size | input | 2 | Lane size code |
| vec_a | input | VBITS (256) | First operand vector |
| vec_b | input | VBITS (256) | Second operand vector |
| gov_pred | input | VBITS/8 (32) | Governing predicate, one bit per byte |
| ftz_half | input | 1 | Flush denormals for 16-bit lanes |
| ftz_wide | input | 1 | Flush denormals for 32/64-bit lanes |
| flag_clr | input | 1 | Clear the sticky invalid flag |
| res_valid | output | 1 | Result predicate valid |
| res_pred | output | VBITS/8 (32) | Result predicate |
| undef_enc | output | 1 | Request was an undefined encoding |
| inv_sticky | output | 1 | Sticky invalid-operation flag |

## Verification
A wrong lane-start decode or activity mask shows up in the very next result cycle: either a 1 appears in a non-leading bit of a lane's span, or a lane that is off reports a result. Faulty NaN classification shows up in the same cycle as a wrong predicate bit, or as an invalid flag that rises, or fails to rise, on one operand pattern. Because the flag is sticky, a wrong contribution persists and is seen on every later result until the next clear. For that reason the checks clear the flag before the requests that test the signalling rules.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic [2:0] {
    REL_GE, REL_GT, REL_EQ, REL_NE, REL_UO, REL_AGE, REL_AGT, REL_BAD
  } rel_e;

  typedef struct packed {
    logic        sign;
    logic        nan;
    logic        snan;
    logic        zero;
    logic [62:0] mag;
  } fp_view_t;

  // Split a lane (right-aligned in 64 bits) into sign, class and magnitude
  function automatic fp_view_t fp_view(input logic [63:0] x, input logic [1:0] sz,
                                       input logic ftz);
    fp_view_t v;
    logic e_ones, e_zero, m_nz, q_bit;
    v = '0;
    e_ones = 1'b0; e_zero = 1'b0; m_nz = 1'b0; q_bit = 1'b0;
    case (sz)
      2'd1: begin
        v.sign = x[15]; e_ones = &x[14:10]; e_zero = ~|x[14:10];
        m_nz = |x[9:0]; q_bit = x[9]; v.mag = {48'b0, x[14:0]};
      end
      2'd2: begin
        v.sign = x[31]; e_ones = &x[30:23]; e_zero = ~|x[30:23];
        m_nz = |x[22:0]; q_bit = x[22]; v.mag = {32'b0, x[30:0]};
      end
      2'd3: begin
        v.sign = x[63]; e_ones = &x[62:52]; e_zero = ~|x[62:52];
        m_nz = |x[51:0]; q_bit = x[51]; v.mag = x[62:0];
      end
      default: ;
    endcase
    if (ftz && e_zero) v.mag = '0;
    v.nan  = e_ones & m_nz;
    v.snan = e_ones & m_nz & ~q_bit;
    v.zero = (v.mag == '0);
    return v;
  endfunction

  // a > b for non-NaN operands
  function automatic logic fp_gt(input fp_view_t a, input fp_view_t b);
    if (a.zero && b.zero)     return 1'b0;
    else if (a.sign != b.sign) return ~a.sign;
    else if (!a.sign)          return a.mag > b.mag;
    else                       return a.mag < b.mag;
  endfunction

  // a == b for non-NaN operands (signed zeros are equal)
  function automatic logic fp_eq(input fp_view_t a, input fp_view_t b);
    return (a.zero && b.zero) || (a.sign == b.sign && a.mag == b.mag);
  endfunction

endpackage

// File: rtl/vfc_decode.sv
module vfc_decode
  import vfc_pkg::*;
(
  input  logic [2:0] op_field,
  input  logic       op_bit,
  input  logic [1:0] elem_size,
  output rel_e       rel,
  output logic       undef
);
  always_comb begin
    case ({op_field, op_bit})
      4'b010_0: rel = REL_GE;
      4'b010_1: rel = REL_GT;
      4'b011_0: rel = REL_EQ;
      4'b011_1: rel = REL_NE;
      4'b110_0: rel = REL_UO;
      4'b110_1: rel = REL_AGE;
      4'b111_1: rel = REL_AGT;
      default:  rel = REL_BAD;
    endcase
    undef = (rel == REL_BAD) || (elem_size == 2'd0);
  end
endmodule

// File: rtl/vfc_lane.sv
module vfc_lane
  import vfc_pkg::*;
(
  input  logic [63:0] a_bits,
  input  logic [63:0] b_bits,
  input  logic [1:0]  elem_size,
  input  rel_e        rel,
  input  logic        ftz,
  output logic        hit,
  output logic        inv,
  output logic        any_nan
);
  fp_view_t va, vb;
  logic     is_abs, nan_any, snan_any, gt_w, eq_w;

  always_comb begin
    is_abs = (rel == REL_AGE) || (rel == REL_AGT);
    va = fp_view(a_bits, elem_size, ftz);
    vb = fp_view(b_bits, elem_size, ftz);
    if (is_abs) begin
      va.sign = 1'b0;
      vb.sign = 1'b0;
    end
    nan_any  = va.nan | vb.nan;
    snan_any = va.snan | vb.snan;
    gt_w     = fp_gt(va, vb);
    eq_w     = fp_eq(va, vb);
    hit = 1'b0;
    inv = 1'b0;
    case (rel)
      REL_GE, REL_AGE: begin hit = ~nan_any & (gt_w | eq_w); inv = nan_any;  end
      REL_GT, REL_AGT: begin hit = ~nan_any & gt_w;          inv = nan_any;  end
      REL_EQ:          begin hit = ~nan_any & eq_w;          inv = snan_any; end
      REL_NE:          begin hit = nan_any | ~eq_w;          inv = snan_any; end
      REL_UO:          begin hit = nan_any;                  inv = snan_any; end
      default: ;
    endcase
    any_nan = nan_any;
  end
endmodule

// File: rtl/vfp_cmp_top.sv
module vfp_cmp_top
  import vfc_pkg::*;
#(
  parameter int VBITS = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         op_field,
  input  logic               op_bit,
  input  logic [1:0]         elem_size,
  input  logic [VBITS-1:0]   vec_a,
  input  logic [VBITS-1:0]   vec_b,
  input  logic [VBITS/8-1:0] gov_pred,
  input  logic               ftz_half,
  input  logic               ftz_wide,
  input  logic               flag_clr,
  output logic               res_valid,
  output logic [VBITS/8-1:0] res_pred,
  output logic               undef_enc,
  output logic               inv_sticky
);
  localparam int NB    = VBITS / 8;
  localparam int SLOTS = VBITS / 16;
  localparam int PADW  = VBITS + 48;

  rel_e             rel;
  logic             undef;
  logic             ftz_sel;
  logic [PADW-1:0]  a_pad, b_pad;
  logic [SLOTS-1:0] lane_act, lane_hit, lane_inv, lane_nan;
  logic [NB-1:0]    pred_comb;
  logic             inv_any;

  vfc_decode u_dec (
    .op_field (op_field),
    .op_bit   (op_bit),
    .elem_size(elem_size),
    .rel      (rel),
    .undef    (undef)
  );

  assign ftz_sel = (elem_size == 2'd1) ? ftz_half : ftz_wide;
  assign a_pad   = {48'b0, vec_a};
  assign b_pad   = {48'b0, vec_b};

  // One comparator per 16-bit slot; only slots that open a lane are used
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam bit EVEN2 = (s % 2) == 0;
    localparam bit EVEN4 = (s % 4) == 0;
    logic starts;
    logic hit_w, inv_w, nan_w;

    assign starts = (elem_size == 2'd1) ||
                    (elem_size == 2'd2 && EVEN2) ||
                    (elem_size == 2'd3 && EVEN4);

    vfc_lane u_lane (
      .a_bits   (a_pad[16*s +: 64]),
      .b_bits   (b_pad[16*s +: 64]),
      .elem_size(elem_size),
      .rel      (rel),
      .ftz      (ftz_sel),
      .hit      (hit_w),
      .inv      (inv_w),
      .any_nan  (nan_w)
    );

    assign lane_act[s]      = starts & gov_pred[2*s];
    assign lane_hit[s]      = hit_w;
    assign lane_inv[s]      = inv_w;
    assign lane_nan[s]      = nan_w;
    assign pred_comb[2*s]   = lane_act[s] & hit_w;
    assign pred_comb[2*s+1] = 1'b0;
  end

  assign inv_any = |(lane_act & lane_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_pred   <= '0;
      undef_enc  <= 1'b0;
      inv_sticky <= 1'b0;
    end else begin
      res_valid  <= in_valid;
      res_pred   <= (in_valid && !undef) ? pred_comb : '0;
      undef_enc  <= in_valid & undef;
      inv_sticky <= (flag_clr ? 1'b0 : inv_sticky) | (in_valid & ~undef & inv_any);
    end
  end

  // ---------------- assertions ----------------
  function automatic logic [NB-1:0] lead_mask(input logic [1:0] sz);
    logic [NB-1:0] m;
    for (int b = 0; b < NB; b++)
      m[b] = (sz == 2'd1) ? (b % 2 == 0) : (sz == 2'd2) ? (b % 4 == 0) :
             (sz == 2'd3) ? (b % 8 == 0) : 1'b0;
    return m;
  endfunction

  logic ordered_rel;
  assign ordered_rel = (rel == REL_GE) || (rel == REL_GT) ||
                       (rel == REL_AGE) || (rel == REL_AGT);

  assert_span_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_pred & ~lead_mask($past(elem_size))) == '0);

  assert_inactive_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_pred & ~$past(gov_pred)) == '0);

  assert_undef_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && undef && !flag_clr) |=> (res_pred == '0 && $stable(inv_sticky)));

  assert_ordered_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !undef && ordered_rel && |(lane_nan & lane_act)) |=> inv_sticky);

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_sticky) |-> $past(flag_clr));

  assert_result_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> res_pred == '0);

  logic unused_ok;
  assign unused_ok = ^lane_hit;

endmodule

// File: tb/sim_vfp_cmp_top.sv
module sim_vfp_cmp_top;
  localparam int CLK_PERIOD = 10;
  localparam int VB = 256;
  localparam int NB = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    op_field = '0;
  logic          op_bit = 1'b0;
  logic [1:0]    elem_size = 2'd2;
  logic [VB-1:0] vec_a = '0, vec_b = '0;
  logic [NB-1:0] gov_pred = '0;
  logic          ftz_half = 1'b0, ftz_wide = 1'b0, flag_clr = 1'b0;
  logic          res_valid, undef_enc, inv_sticky;
  logic [NB-1:0] res_pred;

  int checks = 0;
  int errors = 0;
  bit sticky_m = 1'b0;

  logic [NB-1:0] q_pred[$];
  logic          q_undef[$];
  logic          q_inv[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vfp_cmp_top #(.VBITS(VB)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_field(op_field),
    .op_bit(op_bit), .elem_size(elem_size), .vec_a(vec_a), .vec_b(vec_b),
    .gov_pred(gov_pred), .ftz_half(ftz_half), .ftz_wide(ftz_wide),
    .flag_clr(flag_clr), .res_valid(res_valid), .res_pred(res_pred),
    .undef_enc(undef_enc), .inv_sticky(inv_sticky)
  );

  // ---------------- reference model ----------------
  function automatic real inf_r();
    return $bitstoreal(64'h7FF0_0000_0000_0000);
  endfunction

  function automatic real to_real(input logic [63:0] x, input int sz, input bit ftz);
    real v;
    int  e;
    longint m;
    if (sz == 8) begin
      if (ftz && x[62:52] == 0) return 0.0;
      return $bitstoreal(x);
    end
    if (sz == 2) begin e = int'(x[14:10]); m = longint'(x[9:0]); end
    else         begin e = int'(x[30:23]); m = longint'(x[22:0]); end
    if (e == 0) v = ftz ? 0.0 : ((sz == 2) ? real'(m) * 2.0 ** (-24) : real'(m) * 2.0 ** (-149));
    else if ((sz == 2 && e == 31) || (sz == 4 && e == 255)) v = inf_r();
    else if (sz == 2) v = (1024.0 + real'(m)) * 2.0 ** (e - 25);
    else              v = (8388608.0 + real'(m)) * 2.0 ** (e - 150);
    if ((sz == 2 && x[15]) || (sz == 4 && x[31])) v = -v;
    return v;
  endfunction

  function automatic logic [1:0] nan_class(input logic [63:0] x, input int sz); // {nan, snan}
    logic n, q;
    case (sz)
      2: begin n = (x[14:10] == 5'h1F) && (x[9:0] != 0); q = x[9]; end
      4: begin n = (x[30:23] == 8'hFF) && (x[22:0] != 0); q = x[22]; end
      default: begin n = (x[62:52] == 11'h7FF) && (x[51:0] != 0); q = x[51]; end
    endcase
    return {n, n & ~q};
  endfunction

  function automatic logic [1:0] elem_model(input logic [3:0] code, input int sz,
      input logic [63:0] xa, input logic [63:0] xb, input bit ftz); // {hit, inv}
    logic [1:0] ca, cb;
    bit  nan, snan;
    real ra, rb;
    ca = nan_class(xa, sz); cb = nan_class(xb, sz);
    nan = ca[1] | cb[1]; snan = ca[0] | cb[0];
    ra = to_real(xa, sz, ftz); rb = to_real(xb, sz, ftz);
    if (code == 4'b1101 || code == 4'b1111) begin
      if (ra < 0.0) ra = -ra;
      if (rb < 0.0) rb = -rb;
    end
    case (code)
      4'b0100, 4'b1101: return nan ? 2'b01 : {ra >= rb, 1'b0};
      4'b0101, 4'b1111: return nan ? 2'b01 : {ra > rb, 1'b0};
      4'b0110: return nan ? {1'b0, snan} : {ra == rb, 1'b0};
      4'b0111: return nan ? {1'b1, snan} : {ra != rb, 1'b0};
      4'b1100: return {nan, snan};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [63:0] fp_const(input int idx, input int sz);
    logic [63:0] h[11] = '{64'h3C00, 64'h4000, 64'hBC00, 64'h0, 64'h8000, 64'h7C00,
                          64'hFC00, 64'h7E00, 64'h7C01, 64'h0001, 64'hC000};
    logic [63:0] s[11] = '{64'h3F80_0000, 64'h4000_0000, 64'hBF80_0000, 64'h0,
                          64'h8000_0000, 64'h7F80_0000, 64'hFF80_0000, 64'h7FC0_0000,
                          64'h7F80_0001, 64'h0000_0001, 64'hC000_0000};
    logic [63:0] d[11] = '{64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
                          64'hBFF0_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000,
                          64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
                          64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001,
                          64'h0000_0000_0000_0001, 64'hC000_0000_0000_0000};
    return (sz == 2) ? h[idx] : (sz == 4) ? s[idx] : d[idx];
  endfunction

  function automatic logic [VB-1:0] mkvec(input int sz, input int seed, input int mul);
    logic [VB-1:0] v, p;
    v = '0;
    for (int i = 0; i < VB / (sz * 8); i++) begin
      p = '0;
      p[63:0] = fp_const((i * mul + seed) % 11, sz);
      v = v | (p << (i * sz * 8));
    end
    return v;
  endfunction

  function automatic logic [VB-1:0] fill(input int sz, input logic [63:0] pat);
    logic [VB-1:0] v, p;
    v = '0;
    for (int i = 0; i < VB / (sz * 8); i++) begin
      p = '0;
      p[63:0] = pat;
      v = v | (p << (i * sz * 8));
    end
    return v;
  endfunction

  // ---------------- driver ----------------
  task automatic issue(input logic [2:0] f, input logic b4, input logic [1:0] esz,
                       input logic [VB-1:0] a, input logic [VB-1:0] b,
                       input logic [NB-1:0] g, input bit fh, input bit fw,
                       input bit clr, input string tag);
    logic [3:0]    code;
    logic [NB-1:0] pe;
    logic [VB-1:0] sa, sb;
    logic [63:0]   mask, xa, xb;
    logic [1:0]    r;
    bit            und, iv;
    int            sz;
    @(negedge clk);
    in_valid = 1'b1; op_field = f; op_bit = b4; elem_size = esz;
    vec_a = a; vec_b = b; gov_pred = g; ftz_half = fh; ftz_wide = fw; flag_clr = clr;
    code = {f, b4};
    und = (esz == 2'd0) || !(code inside {4'b0100, 4'b0101, 4'b0110, 4'b0111,
                                          4'b1100, 4'b1101, 4'b1111});
    sz = (esz == 2'd1) ? 2 : (esz == 2'd2) ? 4 : 8;
    mask = (sz == 8) ? '1 : ((64'd1 << (sz * 8)) - 64'd1);
    pe = '0; iv = 1'b0;
    if (!und) begin
      for (int e = 0; e < NB / sz; e++) begin
        if (g[e * sz]) begin
          sa = a >> (e * sz * 8); sb = b >> (e * sz * 8);
          xa = sa[63:0] & mask;   xb = sb[63:0] & mask;
          r = elem_model(code, sz, xa, xb, (sz == 2) ? fh : fw);
          pe[e * sz] = r[1];
          iv = iv | r[0];
        end
      end
    end
    if (clr) sticky_m = 1'b0;
    sticky_m = sticky_m | iv;
    q_pred.push_back(pe); q_undef.push_back(und); q_inv.push_back(sticky_m);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        if (q_pred.size() == 0) begin
          check(1'b0, "R11 unexpected result", 64'(res_pred), 64'h0);
        end else begin
          logic [NB-1:0] ep;
          logic eu, ei;
          string t;
          ep = q_pred.pop_front(); eu = q_undef.pop_front();
          ei = q_inv.pop_front();  t = q_tag.pop_front();
          check(res_pred == ep, {t, " pred"}, 64'(res_pred), 64'(ep));
          check(undef_enc == eu, {t, " undef"}, 64'(undef_enc), 64'(eu));
          check(inv_sticky == ei, {t, " invalid"}, 64'(inv_sticky), 64'(ei));
        end
      end else begin
        check(res_pred == '0, "R11 idle predicate", 64'(res_pred), 64'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [2:0] of[7] = '{3'b010, 3'b010, 3'b011, 3'b011, 3'b110, 3'b110, 3'b111};
    logic       ob[7] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    string      ot[7] = '{"R1 R5 ge", "R1 R5 gt", "R1 R6 eq", "R1 R6 ne",
                          "R1 R6 uo", "R1 R7 age", "R1 R7 agt"};
    repeat (3) @(negedge clk);
    check(res_valid == 0 && res_pred == '0 && inv_sticky == 0 && undef_enc == 0,
          "R11 reset state", {res_valid, undef_enc, inv_sticky}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: all relations, all sizes, varied operand pairs and predicates (R3 R4 R8)
    for (int z = 1; z <= 3; z++) begin
      for (int o = 0; o < 7; o++) begin
        for (int sd = 0; sd < 5; sd++) begin
          int sz = (z == 1) ? 2 : (z == 2) ? 4 : 8;
          issue(of[o], ob[o], 2'(z), mkvec(sz, sd, 1), mkvec(sz, sd * 2 + 1, sd + 2),
                (sd % 2 == 0) ? '1 : (32'hA5C3_0F69 ^ 32'(sd * 7)),
                sd[0], sd[1], (sd == 0), $sformatf("%s R3 R4 R8 size%0d", ot[o], sz));
        end
      end
    end
    idle(2);

    // R8: signed zeros equal, infinity ordering
    issue(3'b011, 1'b0, 2'd2, fill(4, 64'h8000_0000), fill(4, 64'h0), '1, 0, 0, 1, "R8 +0 == -0");
    issue(3'b010, 1'b1, 2'd3, fill(8, 64'h7FF0_0000_0000_0000),
          fill(8, 64'h4000_0000_0000_0000), '1, 0, 0, 0, "R8 +inf > 2.0");
    issue(3'b010, 1'b1, 2'd1, fill(2, 64'hFC00), fill(2, 64'hC000), '1, 0, 0, 0, "R8 -inf > -2.0 false");

    // R4: only non-leading governing bits set, NaN operands -> no result, no flag
    issue(3'b010, 1'b0, 2'd2, fill(4, 64'h7FC0_0000), fill(4, 64'h7FC0_0000),
          32'hEEEE_EEEE, 0, 0, 1, "R4 off lanes ignore NaN");
    // R6: quiet NaN under equal does not flag; signalling does
    issue(3'b011, 1'b0, 2'd2, fill(4, 64'h7FC0_0000), fill(4, 64'h3F80_0000), '1, 0, 0, 1, "R6 qnan quiet");
    issue(3'b011, 1'b1, 2'd2, fill(4, 64'h7F80_0001), fill(4, 64'h3F80_0000), '1, 0, 0, 1, "R6 snan flags");
    // R5: quiet NaN under ordered compare flags
    issue(3'b010, 1'b1, 2'd3, fill(8, 64'h7FF8_0000_0000_0000), fill(8, 64'h0), '1, 0, 0, 1, "R5 qnan flags");
    // R7: magnitudes ignore sign
    issue(3'b110, 1'b1, 2'd1, fill(2, 64'hC000), fill(2, 64'h4000), '1, 0, 0, 1, "R7 |-2| >= |2|");
    issue(3'b111, 1'b1, 2'd2, fill(4, 64'hC000_0000), fill(4, 64'h3F80_0000), '1, 0, 0, 0, "R7 |-2| > |1|");

    // R9: denormal vs zero with each flush control
    issue(3'b011, 1'b0, 2'd1, fill(2, 64'h0001), fill(2, 64'h0), '1, 1, 0, 0, "R9 half flushed");
    issue(3'b011, 1'b0, 2'd1, fill(2, 64'h0001), fill(2, 64'h0), '1, 0, 1, 0, "R9 half wide-ftz no effect");
    issue(3'b011, 1'b0, 2'd2, fill(4, 64'h0001), fill(4, 64'h0), '1, 1, 0, 0, "R9 single half-ftz no effect");
    issue(3'b011, 1'b0, 2'd3, fill(8, 64'h0001), fill(8, 64'h0), '1, 0, 1, 0, "R9 double flushed");

    // R2: undefined encodings
    issue(3'b010, 1'b0, 2'd0, fill(4, 64'h7FC0_0000), fill(4, 64'h0), '1, 0, 0, 0, "R2 size 00");
    issue(3'b111, 1'b0, 2'd2, fill(4, 64'h7FC0_0000), fill(4, 64'h0), '1, 0, 0, 0, "R2 op 111/0");
    issue(3'b000, 1'b1, 2'd3, fill(8, 64'h7FF8_0000_0000_0000), fill(8, 64'h0), '1, 0, 0, 0, "R2 op 000/1");
    idle(1);

    // R10: clear alone drops the flag
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    sticky_m = 1'b0;
    check(inv_sticky == 1'b0, "R10 clear", 64'(inv_sticky), 64'h0);
    // R10: clear and a flagging request at the same edge keep the new flag
    issue(3'b010, 1'b0, 2'd2, fill(4, 64'h7FC0_0000), fill(4, 64'h0), 32'h1, 0, 0, 1, "R10 clear+flag");
    issue(3'b010, 1'b0, 2'd2, fill(4, 64'h3F80_0000), fill(4, 64'h0), '1, 0, 0, 0, "R10 flag holds");
    idle(3);
    check(q_pred.size() == 0, "R11 all results seen", 64'(q_pred.size()), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule